// File: doc/BRIEF.md
# Packed String Compare Engine

This block compares two packed operands element by element and condenses the outcome into a bit mask over the second operand. Each operand is either a vector of bytes or a vector of 16-bit words, and the element size is chosen with every request. Each operand is treated as a string that stops at its first zero element. The engine first forms every pairing of a first-operand element with a second-operand element. It then folds that grid in one of four ways: a per-lane equality test, a character-set membership test, an inclusive range test, and a substring search.

A request is presented with `in_valid`. One clock later `out_valid` rises, together with the mask, the index of its lowest set bit, and two flags that report whether either operand ended inside the vector. A software scanning loop can advance by the index and stop once a flag shows that a terminator was seen.

Top module: `pstr_match`

## Requirements
- R1: When `in_valid` is sampled high on a rising edge, `out_valid` is high after that edge and the result outputs hold that request's result. When `in_valid` is sampled low, `out_valid` is low and the result outputs keep their previous values. A synchronous high `rst` clears `out_valid`, `mask`, `index`, `a_end` and `b_end` to zero.
- R2: With `wide`=0 the operand holds 16 bytes, and element i is bits [8i+7:8i]. With `wide`=1 it holds 8 words, and element i is bits [16i+15:16i]. Mask bits at or above the element count are always zero.
- R3: The length of an operand is the position of its first zero element, or the element count when it has none. No element at or after that position ever matches. In every mode except the substring search, no mask bit at or beyond the second operand's length is set.
- R4: Per-lane equality (`mode`=0): mask bit j is set when element j of both operands lies before its operand's end and the two elements are equal.
- R5: Set membership (`mode`=1): mask bit j is set when element j of the second operand lies before its end and equals some element of the first operand that lies before the first operand's end.
- R6: Range test (`mode`=2): first-operand elements 2k and 2k+1 form an unsigned inclusive range [low, high]. A pair counts only when element 2k+1 lies before the first operand's end. Mask bit j is set when element j of the second operand lies before its end and falls inside at least one counting range.
- R7: Substring search (`mode`=3): mask bit j is set when, for every k below the first operand's length, position j+k lies before the second operand's end and element j+k of the second operand equals element k of the first. An empty first operand sets every mask bit below the element count.
- R8: `index` equals the position of the lowest set mask bit, or the element count (16 or 8) when the mask is zero.
- R9: `b_end` is set when the second operand contains a zero element within the element count. `a_end` is set likewise for the first operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands and controls are sampled on this edge |
| op_a | input | 128 | First operand: needle, character set or range pairs |
| op_b | input | 128 | Second operand: the data scanned |
| wide | input | 1 | Element size: 0 selects bytes, 1 selects 16-bit words |
| mode | input | 2 | Aggregation: 0 per-lane equality, 1 membership, 2 ranges, 3 substring |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| mask | output | 16 | One bit per second-operand element |
| index | output | 5 | Lowest set mask bit, or element count if none |
| a_end | output | 1 | First operand contains a terminator |
| b_end | output | 1 | Second operand contains a terminator |

## Verification
The bench builds the engine with its default 128-bit operand width. That width gives 16 byte lanes or 8 word lanes, so the same operand bits are checked under both element sizes. With this width, a word whose low byte is zero ends a byte string but not a word string. The width also allows a full-length operand with no terminator, an empty operand in both positions, a substring match cut short by the end of the second operand, and a range list whose last pair is incomplete.

// File: rtl/pstr_pkg.sv
package pstr_pkg;

    // Aggregation selector; the encoding is visible on the mode port.
    typedef enum logic [1:0] {
        AGG_EACH  = 2'd0,
        AGG_ANY   = 2'd1,
        AGG_RANGE = 2'd2,
        AGG_ORDER = 2'd3
    } agg_e;

    // Per-request configuration carried through the datapath.
    typedef struct packed {
        logic wide;
        agg_e mode;
    } op_cfg_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

    // Number of live lanes for a given operand width and element size.
    function automatic int unsigned lane_count(input int unsigned data_w, input logic wide);
        return wide ? data_w / WORD_W : data_w / BYTE_W;
    endfunction

endpackage

// File: rtl/pstr_term.sv
// Finds the first zero element of one operand and marks the lanes before it.
module pstr_term
    import pstr_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    localparam int unsigned NB    = DATA_W / BYTE_W,
    localparam int unsigned NW    = DATA_W / WORD_W,
    localparam int unsigned IDX_W = $clog2(NB + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic              wide,
    output logic [IDX_W-1:0]  len,
    output logic [NB-1:0]     live
);

    logic [NB-1:0] zero_lane;

    for (genvar i = 0; i < NB; i++) begin : g_zero
        if (i < NW) begin : g_both
            assign zero_lane[i] = wide ? (data[WORD_W*i +: WORD_W] == '0)
                                       : (data[BYTE_W*i +: BYTE_W] == '0);
        end else begin : g_byte_only
            assign zero_lane[i] = wide ? 1'b0 : (data[BYTE_W*i +: BYTE_W] == '0);
        end
    end

    always_comb begin
        int unsigned cnt;
        cnt = lane_count(DATA_W, wide);
        len = IDX_W'(cnt);
        for (int i = NB - 1; i >= 0; i--) begin
            if ((i < int'(cnt)) && zero_lane[i]) begin
                len = IDX_W'(i);
            end
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_live
        assign live[i] = (IDX_W'(i) < len);
    end

endmodule

// File: rtl/pstr_matrix.sv
// Full grid of element-pair comparisons: row i is a first-operand element,
// column j a second-operand element.
module pstr_matrix
    import pstr_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    localparam int unsigned NB    = DATA_W / BYTE_W,
    localparam int unsigned NW    = DATA_W / WORD_W
) (
    input  logic [DATA_W-1:0]        op_a,
    input  logic [DATA_W-1:0]        op_b,
    input  logic                     wide,
    output logic [NB-1:0][NB-1:0]    eq,   // eq[i][j]: b_j == a_i
    output logic [NB-1:0][NB-1:0]    ge,   // ge[i][j]: b_j >= a_i
    output logic [NB-1:0][NB-1:0]    le    // le[i][j]: b_j <= a_i
);

    logic [WORD_W-1:0] ea [NB];
    logic [WORD_W-1:0] eb [NB];

    for (genvar i = 0; i < NB; i++) begin : g_elem
        if (i < NW) begin : g_both
            assign ea[i] = wide ? op_a[WORD_W*i +: WORD_W]
                                : {{(WORD_W-BYTE_W){1'b0}}, op_a[BYTE_W*i +: BYTE_W]};
            assign eb[i] = wide ? op_b[WORD_W*i +: WORD_W]
                                : {{(WORD_W-BYTE_W){1'b0}}, op_b[BYTE_W*i +: BYTE_W]};
        end else begin : g_byte_only
            assign ea[i] = wide ? '0 : {{(WORD_W-BYTE_W){1'b0}}, op_a[BYTE_W*i +: BYTE_W]};
            assign eb[i] = wide ? '0 : {{(WORD_W-BYTE_W){1'b0}}, op_b[BYTE_W*i +: BYTE_W]};
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_row
        for (genvar j = 0; j < NB; j++) begin : g_col
            assign eq[i][j] = (eb[j] == ea[i]);
            assign ge[i][j] = (eb[j] >= ea[i]);
            assign le[i][j] = (eb[j] <= ea[i]);
        end
    end

endmodule

// File: rtl/pstr_reduce.sv
// Folds the comparison grid into a mask over the second operand.
module pstr_reduce
    import pstr_pkg::*;
#(
    parameter int unsigned NB = 16
) (
    input  agg_e                  mode,
    input  logic [NB-1:0][NB-1:0] eq,
    input  logic [NB-1:0][NB-1:0] ge,
    input  logic [NB-1:0][NB-1:0] le,
    input  logic [NB-1:0]         live_a,
    input  logic [NB-1:0]         live_b,
    input  logic [NB-1:0]         lane_on,
    output logic [NB-1:0]         mask
);

    localparam int unsigned NPAIR = NB / 2;

    logic [NB-1:0] each_m, any_m, rng_m, ord_m;

    // Diagonal: lane j against lane j.
    for (genvar j = 0; j < NB; j++) begin : g_each
        assign each_m[j] = eq[j][j] & live_a[j] & live_b[j];
    end

    // Column OR over live first-operand elements.
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            any_m[j] = 1'b0;
            for (int i = 0; i < NB; i++) begin
                any_m[j] = any_m[j] | (eq[i][j] & live_a[i]);
            end
            any_m[j] = any_m[j] & live_b[j];
        end
    end

    // Pairs (2k, 2k+1) give low/high bounds; both must be live.
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            rng_m[j] = 1'b0;
            for (int k = 0; k < NPAIR; k++) begin
                rng_m[j] = rng_m[j] | (ge[2*k][j] & le[2*k+1][j] & live_a[2*k+1]);
            end
            rng_m[j] = rng_m[j] & live_b[j];
        end
    end

    // Diagonal AND: needle element k against haystack element j+k.
    // Dead needle lanes pass; a live needle lane past the haystack end fails.
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            ord_m[j] = lane_on[j];
            for (int k = 0; k < NB; k++) begin
                if (live_a[k]) begin
                    if (j + k < NB) begin
                        ord_m[j] = ord_m[j] & live_b[j+k] & eq[k][j+k];
                    end else begin
                        ord_m[j] = 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        unique case (mode)
            AGG_EACH:  mask = each_m;
            AGG_ANY:   mask = any_m;
            AGG_RANGE: mask = rng_m;
            AGG_ORDER: mask = ord_m;
            default:   mask = '0;
        endcase
    end

endmodule

// File: rtl/pstr_match.sv
module pstr_match
    import pstr_pkg::*;
#(
    parameter int unsigned DATA_W = 128,
    localparam int unsigned NB    = DATA_W / BYTE_W,
    localparam int unsigned NW    = DATA_W / WORD_W,
    localparam int unsigned IDX_W = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              wide,
    input  logic [1:0]        mode,
    output logic              out_valid,
    output logic [NB-1:0]     mask,
    output logic [IDX_W-1:0]  index,
    output logic              a_end,
    output logic              b_end
);

    op_cfg_t cfg;
    assign cfg = '{wide: wide, mode: agg_e'(mode)};

    logic [IDX_W-1:0]      len_a, len_b, cnt;
    logic [NB-1:0]         live_a, live_b, lane_on, mask_c;
    logic [NB-1:0][NB-1:0] eq, ge, le;
    logic [IDX_W-1:0]      index_c;

    assign cnt = IDX_W'(lane_count(DATA_W, cfg.wide));

    for (genvar j = 0; j < NB; j++) begin : g_lane
        if (j < NW) begin : g_low
            assign lane_on[j] = 1'b1;
        end else begin : g_high
            assign lane_on[j] = ~cfg.wide;
        end
    end

    pstr_term #(.DATA_W(DATA_W)) u_term_a (
        .data (op_a),
        .wide (cfg.wide),
        .len  (len_a),
        .live (live_a)
    );

    pstr_term #(.DATA_W(DATA_W)) u_term_b (
        .data (op_b),
        .wide (cfg.wide),
        .len  (len_b),
        .live (live_b)
    );

    pstr_matrix #(.DATA_W(DATA_W)) u_matrix (
        .op_a (op_a),
        .op_b (op_b),
        .wide (cfg.wide),
        .eq   (eq),
        .ge   (ge),
        .le   (le)
    );

    pstr_reduce #(.NB(NB)) u_reduce (
        .mode    (cfg.mode),
        .eq      (eq),
        .ge      (ge),
        .le      (le),
        .live_a  (live_a),
        .live_b  (live_b),
        .lane_on (lane_on),
        .mask    (mask_c)
    );

    // Lowest set bit, scanning down so the lowest wins.
    always_comb begin
        index_c = cnt;
        for (int j = NB - 1; j >= 0; j--) begin
            if (mask_c[j]) begin
                index_c = IDX_W'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mask      <= '0;
            index     <= '0;
            a_end     <= 1'b0;
            b_end     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                mask  <= mask_c;
                index <= index_c;
                a_end <= (len_a < cnt);
                b_end <= (len_b < cnt);
            end
        end
    end

    // R1: a request produces a result strobe on the next cycle only.
    a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: word requests never light lanes above the word count.
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide) |=> ((mask >> NW) == '0));

    // R3: outside substring search, nothing at or past the haystack end matches.
    a_r3_tail_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (agg_e'(mode) != AGG_ORDER)) |-> ((mask_c & ~live_b) == '0));

    // R8: index names the lowest set bit of the registered mask.
    a_r8_index_lowest: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (mask != '0)) |->
            (mask[index] && ((mask & ((NB'(1) << index) - NB'(1))) == '0)));
    a_r8_index_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (mask_c == '0)) |=>
            (index == ($past(wide) ? IDX_W'(NW) : IDX_W'(NB))));

endmodule

// File: tb/test_pstr_match.sv
module test_pstr_match;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] op_a, op_b;
    logic         wide;
    logic [1:0]   mode;
    logic         out_valid;
    logic [15:0]  mask;
    logic [4:0]   index;
    logic         a_end, b_end;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pstr_match i_pstr_match (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .wide      (wide),
        .mode      (mode),
        .out_valid (out_valid),
        .mask      (mask),
        .index     (index),
        .a_end     (a_end),
        .b_end     (b_end)
    );

    typedef struct packed {
        logic         raw;   // 0: text literal, laid out first char at byte 0
        logic         wd;
        logic [1:0]   md;
        logic [127:0] a;
        logic [127:0] b;
        logic [15:0]  msk;
        logic [4:0]   idx;
        logic         za;
        logic         zb;
        logic [3:0]   rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        // R4 per-lane equality, first operand shorter
        '{1'b0, 1'b0, 2'd0, "ABCDEF", "ABXDEZQ", 16'h001B, 5'd0, 1'b1, 1'b1, 4'd4},
        // R5 vowel membership
        '{1'b0, 1'b0, 2'd1, "aeiou", "hello world", 16'h0092, 5'd1, 1'b1, 1'b1, 4'd5},
        // R6 two byte ranges
        '{1'b0, 1'b0, 2'd2, "AZ09", "xY7#Q", 16'h0016, 5'd1, 1'b1, 1'b1, 4'd6},
        // R7 needle found once
        '{1'b0, 1'b0, 2'd3, "AB", "S0BACBAB", 16'h0040, 5'd6, 1'b1, 1'b1, 4'd7},
        // R8 partial match cut by haystack end -> empty mask, index 16
        '{1'b0, 1'b0, 2'd3, "ABZ", "XXAB", 16'h0000, 5'd16, 1'b1, 1'b1, 4'd8},
        // R3 full-length operands, no terminator
        '{1'b0, 1'b0, 2'd1, "0123456789abcdef", "fedcba9876543210", 16'hFFFF, 5'd0, 1'b0, 1'b0, 4'd3},
        // R3 empty second operand
        '{1'b0, 1'b0, 2'd1, "abc", "", 16'h0000, 5'd16, 1'b1, 1'b1, 4'd3},
        // R7 empty needle
        '{1'b0, 1'b0, 2'd3, "", "xyz", 16'hFFFF, 5'd0, 1'b1, 1'b1, 4'd7},
        // R2 word equality
        '{1'b1, 1'b1, 2'd0,
          {16'h0007, 16'h0006, 16'h0005, 16'h0004, 16'h0003, 16'h9ABC, 16'h5678, 16'h1234},
          {16'h0007, 16'h1111, 16'h0005, 16'h0004, 16'h0003, 16'h9ABC, 16'h5600, 16'h1234},
          16'h00BD, 5'd0, 1'b0, 1'b0, 4'd2},
        // R2 same bits as bytes: zero bytes end both strings early
        '{1'b1, 1'b0, 2'd0,
          {16'h0007, 16'h0006, 16'h0005, 16'h0004, 16'h0003, 16'h9ABC, 16'h5678, 16'h1234},
          {16'h0007, 16'h1111, 16'h0005, 16'h0004, 16'h0003, 16'h9ABC, 16'h5600, 16'h1234},
          16'h0003, 5'd0, 1'b1, 1'b1, 4'd2},
        // R6 word ranges
        '{1'b1, 1'b1, 2'd2,
          {64'h0, 16'hFFFF, 16'h8000, 16'h01FF, 16'h0100},
          {64'h0, 16'h0000, 16'h9000, 16'h00FF, 16'h0150},
          16'h0005, 5'd0, 1'b1, 1'b1, 4'd6},
        // R7 word substring, two hits
        '{1'b1, 1'b1, 2'd3,
          {96'h0, 16'h0042, 16'h0041},
          {48'h0, 16'h0042, 16'h0041, 16'h0042, 16'h0041, 16'h0042},
          16'h000A, 5'd1, 1'b1, 1'b1, 4'd7},
        // R6 incomplete last pair is ignored
        '{1'b0, 1'b0, 2'd2, "AZm", "mA", 16'h0002, 5'd1, 1'b1, 1'b1, 4'd6},
        // R2 empty word needle covers only 8 lanes
        '{1'b1, 1'b1, 2'd3, 128'h0, {8{16'h0001}}, 16'h00FF, 5'd0, 1'b1, 1'b0, 4'd2},
        // R9 only the first operand terminates
        '{1'b0, 1'b0, 2'd1, "q", "ABCDEFGHIJKLMNOP", 16'h0000, 5'd16, 1'b1, 1'b0, 4'd9}
    };

    function automatic logic [127:0] lay(input logic [127:0] s);
        int n = 0;
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) if (s[8*i +: 8] != 8'h00) n = i + 1;
        for (int i = 0; i < n; i++) r[8*i +: 8] = s[8*(n-1-i) +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; wide = 1'b0; mode = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(mask == 16'h0,     "R1 reset mask", 32'(mask), 0);
        chk(index == 5'd0,     "R1 reset index", 32'(index), 0);
        chk({a_end, b_end} == 2'b00, "R1 reset flags", 32'({a_end, b_end}), 0);

        for (int v = 0; v < NV; v++) begin
            op_a     = TBL[v].raw ? TBL[v].a : lay(TBL[v].a);
            op_b     = TBL[v].raw ? TBL[v].b : lay(TBL[v].b);
            wide     = TBL[v].wd;
            mode     = TBL[v].md;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == 1'b1, $sformatf("R1 vec%0d valid", v), 32'(out_valid), 1);
            chk(mask == TBL[v].msk, $sformatf("R%0d vec%0d mask", TBL[v].rq, v), 32'(mask), 32'(TBL[v].msk));
            chk(index == TBL[v].idx, $sformatf("R8 vec%0d index", v), 32'(index), 32'(TBL[v].idx));
            chk(a_end == TBL[v].za, $sformatf("R9 vec%0d a_end", v), 32'(a_end), 32'(TBL[v].za));
            chk(b_end == TBL[v].zb, $sformatf("R9 vec%0d b_end", v), 32'(b_end), 32'(TBL[v].zb));
        end

        // R1 idle cycle: strobe drops, results held although inputs change
        op_a = lay("zzz"); op_b = lay("zzz"); mode = 2'd0; wide = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle out_valid", 32'(out_valid), 0);
        chk(mask == 16'h0000 && index == 5'd16, "R1 idle hold", {11'h0, index, mask}, {11'h0, 5'd16, 16'h0});

        // R1 reset wins over a request in the same cycle
        op_a = lay("ab"); op_b = lay("ab"); mode = 2'd0;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(mask == 16'h0003, "R4 pre-reset mask", 32'(mask), 32'h3);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0 && mask == 16'h0, "R1 reset clears", {15'h0, out_valid, mask}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule